// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line priority slices into one fifteen-source interrupt controller. One slice is the primary (head) and one is the secondary (tail). Each slice presents its state on plain input ports: the unmasked pending lines, the in-service lines, its rotation offset and its programmed vector byte. The primary also has a nested-mode flag. Inside the block, one priority resolver per slice picks that slice's winner. The tail's winner is forwarded to head line 2 as a pulse that rises and then falls, so an edge-sensitive head input latches it.

When the processor strobes `ack_i`, a small state machine runs. It decides which slice and which line win, tells each slice which line to mark in service, and returns an 8-bit vector with a one-cycle valid flag. If a request has vanished by the time of the acknowledge, the returned vector is the spurious one: line 7 of the slice concerned. The request line to the processor is frozen while a sequence runs. It takes a fresh value only once the sequence has finished.

The states are `ST_IDLE`, `ST_MSEL` (head selection), `ST_SSEL` (tail selection) and `ST_DONE` (vector valid). The transitions are:
- IDLE to MSEL on a strobe.
- MSEL to SSEL when the head winner is the cascade line.
- MSEL to DONE for any other head winner, or when the head has no winner.
- SSEL to DONE in all cases.
- DONE to IDLE in all cases.

Top module: `cas_ack_top`

## Requirements
- R1: A slice's winner is the first pending line in rotated order. The order starts at line `rot` and goes `rot`, `rot+1`, and so on modulo 8. A winner exists only if its rank is strictly better than the best in-service line ranked the same way.
- R2: When `m_nest_i` is 1, head in-service line 2 is ignored in the head's comparison. When `m_nest_i` is 0, it counts like any other line.
- R3: A head winner other than line 2 is acknowledged on `m_ack_o`/`m_ack_line_o` in the cycle after the strobe. That line is always pending at that moment. The vector is head base plus the line, and `vec_gline_o` equals the line.
- R4: A head winner on line 2 is acknowledged first. One cycle later the tail acknowledges its own winner on `s_ack_o`/`s_ack_line_o`. The vector is tail base plus the tail line, and `vec_gline_o` is 8 plus the tail line (bit 3 selects the tail).
- R5: When the head winner is line 2 but the tail has no winner, `s_ack_o` stays 0. The vector is tail base plus 7, and `vec_gline_o` is 15.
- R6: When the head has no winner at the acknowledge, no acknowledge is raised. The vector is head base plus 7, and `vec_gline_o` is 7.
- R7: Each base is the upper five bits of its slice's vector byte, with the low three bits forced to zero.
- R8: While the tail has a winner, `cas_pulse_o` alternates high for one cycle and low for one cycle, starting high. It is never high two cycles running, and it is high only when the tail had a winner in the previous cycle.
- R9: `vec_valid_o` is high for exactly one cycle. That cycle is 2 cycles after the strobe without a cascade and 3 cycles after it with one. `vec_o` holds its value afterwards.
- R10: `int_req_o` shows whether the head has a winner. It is frozen from the strobe through the valid cycle, and it shows the re-evaluated value in the cycle after that.
- R11: A strobe that arrives while a sequence is running is ignored. A single sequence yields exactly one valid pulse.
- R12: After reset, `int_req_o`, `cas_pulse_o`, `m_ack_o`, `s_ack_o` and `vec_valid_o` are 0, and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_i | input | 1 | Processor acknowledge strobe |
| m_req_i | input | 8 | Head unmasked pending lines |
| m_isr_i | input | 8 | Head in-service lines |
| m_rot_i | input | 3 | Head rotation offset |
| m_nest_i | input | 1 | Head nested mode (ignore in-service line 2) |
| m_base_i | input | 8 | Head vector byte |
| s_req_i | input | 8 | Tail unmasked pending lines |
| s_isr_i | input | 8 | Tail in-service lines |
| s_rot_i | input | 3 | Tail rotation offset |
| s_base_i | input | 8 | Tail vector byte |
| int_req_o | output | 1 | Interrupt request to the processor |
| cas_pulse_o | output | 1 | Drive for head line 2 (tail request) |
| m_ack_o | output | 1 | Head: mark line in service |
| m_ack_line_o | output | 3 | Head line being acknowledged |
| s_ack_o | output | 1 | Tail: mark line in service |
| s_ack_line_o | output | 3 | Tail line being acknowledged |
| vec_o | output | 8 | Returned vector |
| vec_gline_o | output | 4 | Global line number of the vector |
| vec_valid_o | output | 1 | Vector valid, one cycle |

## Verification
The bench counts clock edges from the clock edge that samples the strobe:
- The head acknowledge is visible 1 cycle after that edge.
- The tail acknowledge is visible after 2 cycles.
- The vector and its valid flag are visible after 2 cycles without a cascade and after 3 cycles with one.
- The request line changes on the cycle after that.

The bench samples each of these on the falling edge of the exact cycle predicted from the state sequence. It holds the slice inputs still through selection, so the result reflects the state at acknowledge time. The one deliberate exception is the freeze test: there, the head input changes after head selection has finished, which shows when the request line updates.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSEL = 2'd1,
        ST_SSEL = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cas_prio_pick.sv
// Rotating priority resolver for one slice: winner must outrank in-service.
module cas_prio_pick #(
    parameter int LINES    = 8,
    parameter int LW       = 3,
    parameter int CAS_LINE = 2,
    parameter bit HAS_NEST = 1'b1
) (
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] isr_i,
    input  logic [LW-1:0]    rot_i,
    input  logic             nest_i,
    output logic             win_valid_o,
    output logic [LW-1:0]    win_line_o
);
    logic [LINES-1:0] isr_eff;
    logic [LW:0]      req_rank;
    logic [LW:0]      isr_rank;

    generate
        if (HAS_NEST) begin : g_nest
            always_comb begin
                isr_eff = isr_i;
                if (nest_i) isr_eff[CAS_LINE] = 1'b0;
            end
        end else begin : g_plain
            logic unused_nest;
            assign unused_nest = nest_i;
            assign isr_eff     = isr_i;
        end
    endgenerate

    always_comb begin
        req_rank = (LW+1)'(LINES);
        isr_rank = (LW+1)'(LINES);
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req_i[rot_i + LW'(i)]) req_rank = (LW+1)'(i);
            if (isr_eff[rot_i + LW'(i)]) isr_rank = (LW+1)'(i);
        end
    end

    assign win_valid_o = (req_rank < isr_rank);
    assign win_line_o  = rot_i + req_rank[LW-1:0];
endmodule

// File: rtl/cas_link.sv
// Forwards a tail winner to head line 2 as an alternating rise/fall pulse.
module cas_link (
    input  logic clk,
    input  logic rst_n,
    input  logic s_win_i,
    output logic cas_pulse_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) cas_pulse_o <= 1'b0;
        else        cas_pulse_o <= s_win_i & ~cas_pulse_o;
    end

    a_r8_no_double_high: assert property (@(posedge clk) disable iff (!rst_n)
        cas_pulse_o |=> !cas_pulse_o);
    a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_pulse_o) |-> $past(s_win_i));
endmodule

// File: rtl/cas_ack_seq.sv
// Acknowledge sequencer: head selection, optional tail selection, vector.
module cas_ack_seq
    import cas_pkg::*;
#(
    parameter int LW       = 3,
    parameter int VEC_W    = 8,
    parameter int CAS_LINE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic             m_win_valid_i,
    input  logic [LW-1:0]    m_win_line_i,
    input  logic             s_win_valid_i,
    input  logic [LW-1:0]    s_win_line_i,
    input  logic [VEC_W-1:0] m_base_i,
    input  logic [VEC_W-1:0] s_base_i,
    output logic             int_req_o,
    output logic             m_ack_o,
    output logic [LW-1:0]    m_ack_line_o,
    output logic             s_ack_o,
    output logic [LW-1:0]    s_ack_line_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [LW:0]      vec_gline_o,
    output logic             vec_valid_o
);
    localparam logic [LW-1:0] SPUR = {LW{1'b1}};
    localparam logic [LW-1:0] CASL = LW'(CAS_LINE);

    seq_state_t state_q, state_d;
    logic       m_is_cas;

    assign m_is_cas = m_win_valid_i && (m_win_line_i == CASL);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ack_i) state_d = ST_MSEL;
            ST_MSEL: state_d = m_is_cas ? ST_SSEL : ST_DONE;
            ST_SSEL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        m_ack_o      = 1'b0;
        m_ack_line_o = m_win_line_i;
        s_ack_o      = 1'b0;
        s_ack_line_o = s_win_line_i;
        vec_valid_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MSEL: m_ack_o = m_win_valid_i;
            ST_SSEL: s_ack_o = s_win_valid_i;
            ST_DONE: vec_valid_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o       <= '0;
            vec_gline_o <= '0;
        end else if (state_q == ST_MSEL && !m_is_cas) begin
            vec_o       <= {m_base_i[VEC_W-1:LW], m_win_valid_i ? m_win_line_i : SPUR};
            vec_gline_o <= {1'b0, m_win_valid_i ? m_win_line_i : SPUR};
        end else if (state_q == ST_SSEL) begin
            vec_o       <= {s_base_i[VEC_W-1:LW], s_win_valid_i ? s_win_line_i : SPUR};
            vec_gline_o <= {1'b1, s_win_valid_i ? s_win_line_i : SPUR};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) int_req_o <= 1'b0;
        else if (state_q == ST_IDLE || state_q == ST_DONE) int_req_o <= m_win_valid_i;
    end

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);
    a_r4_tail_after_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack_o |-> ($past(m_ack_o) && $past(m_ack_line_o) == CASL));
    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_ack_o, s_ack_o, vec_valid_o}));
    a_r10_frozen_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack_o || s_ack_o) |=> $stable(int_req_o));
endmodule

// File: rtl/cas_ack_top.sv
module cas_ack_top #(
    parameter int LINES    = 8,
    parameter int VEC_W    = 8,
    parameter int CAS_LINE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ack_i,
    input  logic [LINES-1:0]         m_req_i,
    input  logic [LINES-1:0]         m_isr_i,
    input  logic [$clog2(LINES)-1:0] m_rot_i,
    input  logic                     m_nest_i,
    input  logic [VEC_W-1:0]         m_base_i,
    input  logic [LINES-1:0]         s_req_i,
    input  logic [LINES-1:0]         s_isr_i,
    input  logic [$clog2(LINES)-1:0] s_rot_i,
    input  logic [VEC_W-1:0]         s_base_i,
    output logic                     int_req_o,
    output logic                     cas_pulse_o,
    output logic                     m_ack_o,
    output logic [$clog2(LINES)-1:0] m_ack_line_o,
    output logic                     s_ack_o,
    output logic [$clog2(LINES)-1:0] s_ack_line_o,
    output logic [VEC_W-1:0]         vec_o,
    output logic [$clog2(LINES):0]   vec_gline_o,
    output logic                     vec_valid_o
);
    localparam int LW = $clog2(LINES);

    logic          m_win_valid, s_win_valid;
    logic [LW-1:0] m_win_line, s_win_line;

    cas_prio_pick #(.LINES(LINES), .LW(LW), .CAS_LINE(CAS_LINE), .HAS_NEST(1'b1)) u_head (
        .req_i(m_req_i), .isr_i(m_isr_i), .rot_i(m_rot_i), .nest_i(m_nest_i),
        .win_valid_o(m_win_valid), .win_line_o(m_win_line)
    );

    cas_prio_pick #(.LINES(LINES), .LW(LW), .CAS_LINE(CAS_LINE), .HAS_NEST(1'b0)) u_tail (
        .req_i(s_req_i), .isr_i(s_isr_i), .rot_i(s_rot_i), .nest_i(1'b0),
        .win_valid_o(s_win_valid), .win_line_o(s_win_line)
    );

    cas_link u_link (
        .clk(clk), .rst_n(rst_n), .s_win_i(s_win_valid), .cas_pulse_o(cas_pulse_o)
    );

    cas_ack_seq #(.LW(LW), .VEC_W(VEC_W), .CAS_LINE(CAS_LINE)) u_seq (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
        .m_win_valid_i(m_win_valid), .m_win_line_i(m_win_line),
        .s_win_valid_i(s_win_valid), .s_win_line_i(s_win_line),
        .m_base_i(m_base_i), .s_base_i(s_base_i),
        .int_req_o(int_req_o),
        .m_ack_o(m_ack_o), .m_ack_line_o(m_ack_line_o),
        .s_ack_o(s_ack_o), .s_ack_line_o(s_ack_line_o),
        .vec_o(vec_o), .vec_gline_o(vec_gline_o), .vec_valid_o(vec_valid_o)
    );

    a_r3_ack_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack_o |-> m_req_i[m_ack_line_o]);
    a_r5_tail_ack_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack_o |-> s_req_i[s_ack_line_o]);
endmodule

// File: tb/cas_ack_top_tb.sv
`timescale 1ns/1ps
module cas_ack_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_i = 1'b0;
    logic [7:0] m_req_i = '0, m_isr_i = '0, m_base_i = 8'h23;
    logic [2:0] m_rot_i = '0;
    logic       m_nest_i = 1'b0;
    logic [7:0] s_req_i = '0, s_isr_i = '0, s_base_i = 8'h75;
    logic [2:0] s_rot_i = '0;
    logic       int_req_o, cas_pulse_o, m_ack_o, s_ack_o, vec_valid_o;
    logic [2:0] m_ack_line_o, s_ack_line_o;
    logic [7:0] vec_o;
    logic [3:0] vec_gline_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cas_ack_top u_dut (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
        .m_req_i(m_req_i), .m_isr_i(m_isr_i), .m_rot_i(m_rot_i), .m_nest_i(m_nest_i),
        .m_base_i(m_base_i), .s_req_i(s_req_i), .s_isr_i(s_isr_i), .s_rot_i(s_rot_i),
        .s_base_i(s_base_i), .int_req_o(int_req_o), .cas_pulse_o(cas_pulse_o),
        .m_ack_o(m_ack_o), .m_ack_line_o(m_ack_line_o), .s_ack_o(s_ack_o),
        .s_ack_line_o(s_ack_line_o), .vec_o(vec_o), .vec_gline_o(vec_gline_o),
        .vec_valid_o(vec_valid_o)
    );

    typedef struct packed {
        logic [7:0] mreq; logic [7:0] misr; logic [2:0] mrot; logic mnest;
        logic [7:0] sreq; logic [7:0] sisr; logic [2:0] srot;
        logic mack; logic [2:0] mline; logic sack; logic [2:0] sline;
        logic [7:0] vec; logic [3:0] gl;
    } row_t;

    // head base 0x23 -> 0x20, tail base 0x75 -> 0x70 (R7)
    localparam row_t TBL [12] = '{
        '{8'h01,8'h00,3'd0,1'b0,8'h00,8'h00,3'd0,1'b1,3'd0,1'b0,3'd0,8'h20,4'd0},
        '{8'h28,8'h00,3'd0,1'b0,8'h00,8'h00,3'd0,1'b1,3'd3,1'b0,3'd0,8'h23,4'd3},
        '{8'h04,8'h00,3'd0,1'b0,8'h10,8'h00,3'd0,1'b1,3'd2,1'b1,3'd4,8'h74,4'd12},
        '{8'h04,8'h00,3'd0,1'b0,8'h00,8'h00,3'd0,1'b1,3'd2,1'b0,3'd0,8'h77,4'd15},
        '{8'h00,8'h00,3'd0,1'b0,8'h00,8'h00,3'd0,1'b0,3'd0,1'b0,3'd0,8'h27,4'd7},
        '{8'h08,8'h02,3'd0,1'b0,8'h00,8'h00,3'd0,1'b0,3'd0,1'b0,3'd0,8'h27,4'd7},
        '{8'h03,8'h00,3'd1,1'b0,8'h00,8'h00,3'd0,1'b1,3'd1,1'b0,3'd0,8'h21,4'd1},
        '{8'h82,8'h00,3'd4,1'b0,8'h00,8'h00,3'd0,1'b1,3'd7,1'b0,3'd0,8'h27,4'd7},
        '{8'h04,8'h04,3'd0,1'b1,8'h01,8'h00,3'd0,1'b1,3'd2,1'b1,3'd0,8'h70,4'd8},
        '{8'h04,8'h04,3'd0,1'b0,8'h01,8'h00,3'd0,1'b0,3'd0,1'b0,3'd0,8'h27,4'd7},
        '{8'h04,8'h00,3'd0,1'b0,8'h20,8'h01,3'd0,1'b1,3'd2,1'b0,3'd0,8'h77,4'd15},
        '{8'h04,8'h00,3'd0,1'b0,8'h03,8'h00,3'd1,1'b1,3'd2,1'b1,3'd1,8'h71,4'd9}
    };

    function automatic string tag_of(input int idx);
        case (idx)
            0:       return "R3 R7";
            1:       return "R1";
            2, 11:   return "R4";
            3, 10:   return "R5";
            4:       return "R6";
            5, 6, 7: return "R1";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 int_req", 32'(int_req_o), 0);
        chk("R12 cas_pulse", 32'(cas_pulse_o), 0);
        chk("R12 acks", 32'({m_ack_o, s_ack_o}), 0);
        chk("R12 vec_valid", 32'(vec_valid_o), 0);
        chk("R12 vec", 32'(vec_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (TBL[k]) begin
            string t;
            t = tag_of(k);
            m_req_i = TBL[k].mreq; m_isr_i = TBL[k].misr; m_rot_i = TBL[k].mrot;
            m_nest_i = TBL[k].mnest; s_req_i = TBL[k].sreq; s_isr_i = TBL[k].sisr;
            s_rot_i = TBL[k].srot;
            @(negedge clk);
            ack_i = 1'b1;
            @(negedge clk);               // state MSEL
            ack_i = 1'b0;
            chk({t, " head ack"}, 32'(m_ack_o), 32'(TBL[k].mack));
            if (TBL[k].mack) chk({t, " head line"}, 32'(m_ack_line_o), 32'(TBL[k].mline));
            if (TBL[k].mack && TBL[k].mline == 3'd2) begin
                @(negedge clk);           // state SSEL
                chk({t, " tail ack"}, 32'(s_ack_o), 32'(TBL[k].sack));
                if (TBL[k].sack) chk({t, " tail line"}, 32'(s_ack_line_o), 32'(TBL[k].sline));
            end
            @(negedge clk);               // state DONE
            chk({t, " R9 valid"}, 32'(vec_valid_o), 1);
            chk({t, " vector"}, 32'(vec_o), 32'(TBL[k].vec));
            chk({t, " global line"}, 32'(vec_gline_o), 32'(TBL[k].gl));
            @(negedge clk);
            chk({t, " R9 valid drop"}, 32'(vec_valid_o), 0);
            chk({t, " R9 vector held"}, 32'(vec_o), 32'(TBL[k].vec));
        end

        // R8: tail winner -> alternating pulse, starting high
        m_req_i = '0; m_isr_i = '0; m_rot_i = '0; m_nest_i = 1'b0;
        s_req_i = '0; s_isr_i = '0; s_rot_i = '0;
        repeat (2) @(negedge clk);
        chk("R8 idle low", 32'(cas_pulse_o), 0);
        s_req_i = 8'h10;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R8 alternating", 32'(cas_pulse_o), 32'((c % 2) == 0));
        end
        s_isr_i = 8'h01;                  // tail blocked: no winner
        @(negedge clk);
        @(negedge clk);
        chk("R8 blocked low", 32'(cas_pulse_o), 0);
        @(negedge clk);
        chk("R8 blocked low", 32'(cas_pulse_o), 0);
        s_req_i = '0; s_isr_i = '0;

        // R11: second strobe during the sequence is ignored
        begin
            int pulses;
            pulses = 0;
            m_req_i = 8'h01;
            @(negedge clk);
            ack_i = 1'b1;
            @(negedge clk);
            @(negedge clk);
            ack_i = 1'b0;
            for (int c = 0; c < 4; c++) begin
                if (vec_valid_o) pulses++;
                @(negedge clk);
            end
            chk("R11 single valid pulse", 32'(pulses), 1);
        end

        // R10: request frozen through the sequence, fresh the cycle after
        m_req_i = 8'h04; s_req_i = 8'h01;
        repeat (2) @(negedge clk);
        chk("R10 request before", 32'(int_req_o), 1);
        ack_i = 1'b1;
        @(negedge clk);                   // MSEL
        ack_i = 1'b0;
        @(negedge clk);                   // SSEL
        m_req_i = 8'h00;
        chk("R10 frozen in tail select", 32'(int_req_o), 1);
        @(negedge clk);                   // DONE
        chk("R10 frozen at valid", 32'(int_req_o), 1);
        chk("R4 cascade vector", 32'(vec_o), 32'h70);
        @(negedge clk);
        chk("R10 updated after", 32'(int_req_o), 0);

        finish_run();
    end
endmodule